// File: doc/BRIEF.md
# BCD Calendar Clock with Transfer-Enable Buffering

This block keeps wall-clock time and calendar date as packed BCD counters: seconds, minutes, 24-hour hours, day of week, date, month, year and century. A one-second increment comes from a prescaler that counts a 32.768 kHz enable input. Software reaches the time through a small register bus. It never sees the live counters directly, only a separate user-visible copy.

A control register holds a transfer-enable bit. While the bit is 1, the user copy follows the live counters every cycle. Clearing the bit freezes the user copy, so software can read a coherent snapshot or write a new time, while the live counters keep advancing. Setting the bit again copies each time field written during the freeze into the live counters. Fields that were not written keep their running values, and tracking resumes.

The same control register holds an oscillator-stop bit, which halts and clears the prescaler, and an enable for a buffered copy of the 32.768 kHz reference.

Top module: `bcd_calendar`

## Requirements
- R1: After reset, time offsets 0..7 read 00, 00, 00, 01, 01, 01, 00, 20 (second, minute, hour, weekday, date, month, year, century). The control register at offset 8 reads 0x01: bit 0 is transfer-enable = 1, bit 1 is oscillator-stop = 0, bit 2 is reference-output-enable = 0. refOut is low.
- R2: With oscillator-stop at 0, the seconds counter advances by one after every TICK_DIV cycles in which refEn is high.
- R3: Seconds and minutes wrap from 59 to 00 and carry into the next field. Hours run 00..23 in 24-hour form and wrap to 00, carrying into the day.
- R4: At midnight the weekday goes from 7 to 1 (otherwise it adds one), and the date advances.
- R5: While transfer-enable is 0, reads of offsets 0..7 return the frozen snapshot, and the live counters keep advancing.
- R6: Writing transfer-enable from 0 to 1 loads every time field written during the freeze into the live counters. Unwritten fields keep their running values. The prescaler does not advance in that cycle.
- R7: The date wraps to 01 after the last day of the month: 30 for months 04, 06, 09 and 11; 28 for month 02, or 29 when year mod 4 is 0; 31 for the other months.
- R8: Month 12 wraps to 01 and carries into the year. Year 99 wraps to 00 and increments the century. Century 39 wraps to 00.
- R9: Constant-zero bits always read 0. Writable masks are 0x7F for second and minute, 0x3F for hour, date and century, 0x07 for weekday, 0x1F for month and 0xFF for year. The control register keeps bits 2..0 only. Offsets 9..15 read 0.
- R10: Writes to offsets 0..7 while transfer-enable is 1 are ignored.
- R11: With oscillator-stop at 1, the prescaler is held at zero and time does not advance. refOut equals refEn when reference-output-enable is 1, and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| refEn | input | 1 | One-cycle enable at the 32.768 kHz reference rate |
| busWe | input | 1 | Register write strobe |
| busAddr | input | ADDR_W | Register offset |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data for busAddr (combinational) |
| refOut | output | 1 | Gated copy of refEn |

## Verification
The bench loads times that sit one or two seconds before a midnight that crosses the end of a 28-day February, a leap-year February 29 and a December 31 at year 99. A wrong month-length table, leap test or century carry would read back the wrong date, month or century after the run. A partial load writes only the minute field while the clock runs frozen. A design that reloads every field would wipe out the running seconds, and one that never freezes the copy would show a snapshot that has moved. Writes while transfer-enable is 1, and writes of all ones, show whether the design leaks writes into the visible registers or keeps constant-zero bits.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam int NUM_TIME  = 8;
  localparam int CTRL_ADDR = 8;

  typedef struct packed {
    logic                tick;
    logic                load;
    logic                track;
    logic [NUM_TIME-1:0] wrSel;
    logic [7:0]          wrData;
  } calStrobe_t;

  function automatic logic [7:0] fieldMask(input int idx);
    case (idx)
      0, 1:    fieldMask = 8'h7F;
      2, 4, 7: fieldMask = 8'h3F;
      3:       fieldMask = 8'h07;
      5:       fieldMask = 8'h1F;
      default: fieldMask = 8'hFF;
    endcase
  endfunction

  function automatic logic [7:0] bcdInc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) bcdInc = {v[7:4] + 4'd1, 4'd0};
    else                bcdInc = {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic [7:0] lastDay(input logic [7:0] month, input logic [7:0] year);
    int y;
    y = int'(year[7:4]) * 10 + int'(year[3:0]);
    case (month)
      8'h02:                      lastDay = ((y % 4) == 0) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: lastDay = 8'h30;
      default:                    lastDay = 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/cal_ctrl.sv
module cal_ctrl
  import cal_pkg::*;
#(
  parameter int TICK_DIV = 32768,
  parameter int ADDR_W   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              refEn,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [7:0]        busWdata,
  output calStrobe_t        strobe,
  output logic [7:0]        ctrlByte,
  output logic              refOut
);
  localparam int CNT_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TICK_DIV - 1);

  logic xferEn, oscStop, outEn;
  logic [CNT_W-1:0] preCnt;
  logic ctrlWr, loadNow;

  assign ctrlWr  = busWe && (int'(busAddr) == CTRL_ADDR);
  assign loadNow = ctrlWr && busWdata[0] && !xferEn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      xferEn  <= 1'b1;
      oscStop <= 1'b0;
      outEn   <= 1'b0;
    end else if (ctrlWr) begin
      xferEn  <= busWdata[0];
      oscStop <= busWdata[1];
      outEn   <= busWdata[2];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || oscStop)        preCnt <= '0;
    else if (refEn && !loadNow)  preCnt <= (preCnt == CNT_LAST) ? '0 : preCnt + 1'b1;
  end

  assign strobe.tick   = refEn && !oscStop && !loadNow && (preCnt == CNT_LAST);
  assign strobe.load   = loadNow;
  assign strobe.track  = xferEn;
  assign strobe.wrData = busWdata;

  for (genvar i = 0; i < NUM_TIME; i++) begin : g_sel
    assign strobe.wrSel[i] = busWe && !xferEn && (int'(busAddr) == i);
  end

  assign ctrlByte = {5'd0, outEn, oscStop, xferEn};
  assign refOut   = outEn && refEn;

  // R11: a stopped oscillator keeps the prescaler at zero
  p_stop_clears_r11: assert property (@(posedge clk) disable iff (!rstN)
    oscStop |=> preCnt == '0);
  // R2: the prescaler must count through its range between ticks
  p_tick_spacing_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.tick |=> (preCnt == '0) && !strobe.tick);
endmodule

// File: rtl/cal_datapath.sv
module cal_datapath
  import cal_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  calStrobe_t        strobe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [7:0]        ctrlByte,
  output logic [7:0]        busRdata
);
  logic [NUM_TIME-1:0][7:0] live, liveNext, user;
  logic [NUM_TIME-1:0]      dirty;
  logic [NUM_TIME:0]        carry;
  logic [NUM_TIME-1:0][7:0] wrapAt, wrapTo;

  always_comb begin
    wrapAt[0] = 8'h59; wrapTo[0] = 8'h00;
    wrapAt[1] = 8'h59; wrapTo[1] = 8'h00;
    wrapAt[2] = 8'h23; wrapTo[2] = 8'h00;
    wrapAt[3] = 8'h07; wrapTo[3] = 8'h01;
    wrapAt[4] = lastDay(live[5], live[6]); wrapTo[4] = 8'h01;
    wrapAt[5] = 8'h12; wrapTo[5] = 8'h01;
    wrapAt[6] = 8'h99; wrapTo[6] = 8'h00;
    wrapAt[7] = 8'h39; wrapTo[7] = 8'h00;
  end

  // weekday and date both advance on the hour carry
  always_comb begin
    carry[0] = strobe.tick;
    carry[1] = carry[0] && (live[0] == wrapAt[0]);
    carry[2] = carry[1] && (live[1] == wrapAt[1]);
    carry[3] = carry[2] && (live[2] == wrapAt[2]);
    carry[4] = carry[3];
    carry[5] = carry[4] && (live[4] == wrapAt[4]);
    carry[6] = carry[5] && (live[5] == wrapAt[5]);
    carry[7] = carry[6] && (live[6] == wrapAt[6]);
    carry[8] = carry[7] && (live[7] == wrapAt[7]);
  end

  for (genvar i = 0; i < NUM_TIME; i++) begin : g_field
    always_comb begin
      if (strobe.load)
        liveNext[i] = dirty[i] ? user[i] : live[i];
      else if (carry[i])
        liveNext[i] = (live[i] == wrapAt[i]) ? wrapTo[i] : bcdInc(live[i]);
      else
        liveNext[i] = live[i];
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        live[i]  <= (i == 3 || i == 4 || i == 5) ? 8'h01 : (i == 7) ? 8'h20 : 8'h00;
        user[i]  <= (i == 3 || i == 4 || i == 5) ? 8'h01 : (i == 7) ? 8'h20 : 8'h00;
        dirty[i] <= 1'b0;
      end else begin
        live[i] <= liveNext[i];
        if (strobe.wrSel[i])   user[i] <= strobe.wrData & fieldMask(i);
        else if (strobe.track) user[i] <= live[i];
        if (strobe.load)          dirty[i] <= 1'b0;
        else if (strobe.wrSel[i]) dirty[i] <= 1'b1;
      end
    end
  end

  always_comb begin
    if (int'(busAddr) < NUM_TIME)        busRdata = user[busAddr[2:0]];
    else if (int'(busAddr) == CTRL_ADDR) busRdata = ctrlByte;
    else                                 busRdata = 8'h00;
  end

  // R3: seconds wrap from 59 to 00 on a tick
  p_sec_wrap_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.tick && (live[0] == 8'h59) |=> live[0] == 8'h00);
  // R4: weekday 7 becomes 1 at midnight
  p_day_wrap_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.tick && (live[2:0] == 24'h235959) && (live[3] == 8'h07) |=> live[3] == 8'h01);
  // R5: the visible copy is held while frozen and not written
  p_frozen_r5: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.track && (strobe.wrSel == '0) |=> $stable(user));
  // R6: every pending field is consumed by a transfer
  p_dirty_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> dirty == '0);
  // R8: year 99 rolls to 00 when the month carry arrives
  p_year_wrap_r8: assert property (@(posedge clk) disable iff (!rstN)
    carry[6] && (live[6] == 8'h99) |=> live[6] == 8'h00);
  // R6: a transfer and a tick never share a cycle
  p_no_tick_on_load_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |-> !strobe.tick);
endmodule

// File: rtl/bcd_calendar.sv
module bcd_calendar
  import cal_pkg::*;
#(
  parameter int TICK_DIV = 32768,
  parameter int ADDR_W   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              refEn,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [7:0]        busWdata,
  output logic [7:0]        busRdata,
  output logic              refOut
);
  calStrobe_t strobe;
  logic [7:0] ctrlByte;

  cal_ctrl #(.TICK_DIV(TICK_DIV), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .refEn(refEn), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .strobe(strobe), .ctrlByte(ctrlByte), .refOut(refOut)
  );

  cal_datapath #(.ADDR_W(ADDR_W)) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busAddr(busAddr),
    .ctrlByte(ctrlByte), .busRdata(busRdata)
  );
endmodule

// File: tb/tb_bcd_calendar.sv
`timescale 1ns/1ps
module tb_bcd_calendar;
  localparam int DIV = 64;

  logic clk = 1'b0, rstN = 1'b0, refEn = 1'b1, busWe = 1'b0;
  logic [3:0] busAddr = '0;
  logic [7:0] busWdata = '0, busRdata;
  logic refOut;
  int checks = 0, fails = 0;
  logic [7:0] expQ[$];
  string tagQ[$];

  always #5 clk = ~clk;

  bcd_calendar #(.TICK_DIV(DIV), .ADDR_W(4)) dut (
    .clk(clk), .rstN(rstN), .refEn(refEn), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .refOut(refOut)
  );

  // monitor: compares each queued expectation at the falling edge
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      logic [7:0] e;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      checks++;
      if (busRdata !== e) begin
        fails++;
        $display("FAIL %s addr=%0h actual=%02h expected=%02h", t, busAddr, busRdata, e);
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(posedge clk); #1 busAddr = a; busWdata = d; busWe = 1'b1;
    @(posedge clk); #1 busWe = 1'b0;
  endtask

  task automatic expect_rd(input logic [3:0] a, input logic [7:0] e, input string t);
    @(posedge clk); #1 busAddr = a;
    expQ.push_back(e); tagQ.push_back(t);
  endtask

  task automatic chk_pin(input logic act, input logic e, input string t);
    checks++;
    if (act !== e) begin
      fails++;
      $display("FAIL %s refOut actual=%0b expected=%0b", t, act, e);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  // load a full time while frozen and stopped, then run for nTicks seconds and freeze/stop
  task automatic load_run(input logic [7:0] v[8], input int nTicks);
    for (int i = 0; i < 8; i++) wr(4'(i), v[i]);
    wr(4'h8, 8'h01);
    idle(nTicks * DIV + DIV / 2);
    wr(4'h8, 8'h02);
    idle(2);
  endtask

  initial begin
    #1_000_000;
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [7:0] v[8];
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1 reset state, R9 unused offsets
    expect_rd(0, 8'h00, "R1 sec");  expect_rd(1, 8'h00, "R1 min");
    expect_rd(2, 8'h00, "R1 hour"); expect_rd(3, 8'h01, "R1 wday");
    expect_rd(4, 8'h01, "R1 date"); expect_rd(5, 8'h01, "R1 month");
    expect_rd(6, 8'h00, "R1 year"); expect_rd(7, 8'h20, "R1 century");
    expect_rd(8, 8'h01, "R1 ctrl"); expect_rd(10, 8'h00, "R9 unused");
    chk_pin(refOut, 1'b0, "R1");

    // R11 stop, R10 write ignored while tracking
    wr(4'h8, 8'h03);
    wr(4'h0, 8'h33);
    idle(3 * DIV);
    wr(4'h8, 8'h02);
    expect_rd(0, 8'h00, "R10/R11 sec");
    expect_rd(8, 8'h02, "R9 ctrl");

    // R9 masks while frozen
    wr(4'h2, 8'hFF); expect_rd(2, 8'h3F, "R9 hour mask");
    wr(4'h3, 8'hFF); expect_rd(3, 8'h07, "R9 wday mask");
    wr(4'h8, 8'hFF); expect_rd(8, 8'h07, "R9 ctrl mask");
    wr(4'h8, 8'h02);

    // R3 R4 R7 non-leap February end
    v = '{8'h58, 8'h59, 8'h23, 8'h07, 8'h28, 8'h02, 8'h23, 8'h20};
    load_run(v, 2);
    expect_rd(0, 8'h00, "R3 sec"); expect_rd(1, 8'h00, "R3 min");
    expect_rd(2, 8'h00, "R3 hour"); expect_rd(3, 8'h01, "R4 wday");
    expect_rd(4, 8'h01, "R7 date"); expect_rd(5, 8'h03, "R7 month");

    // R7 leap year
    v = '{8'h58, 8'h59, 8'h23, 8'h03, 8'h28, 8'h02, 8'h24, 8'h20};
    load_run(v, 2);
    expect_rd(4, 8'h29, "R7 leap date"); expect_rd(5, 8'h02, "R7 leap month");
    expect_rd(3, 8'h04, "R4 wday inc");

    // R7 30-day month
    v = '{8'h59, 8'h59, 8'h23, 8'h02, 8'h30, 8'h04, 8'h24, 8'h20};
    load_run(v, 1);
    expect_rd(4, 8'h01, "R7 apr date"); expect_rd(5, 8'h05, "R7 apr month");

    // R8 year and century
    v = '{8'h59, 8'h59, 8'h23, 8'h05, 8'h31, 8'h12, 8'h99, 8'h20};
    load_run(v, 1);
    expect_rd(4, 8'h01, "R8 date"); expect_rd(5, 8'h01, "R8 month");
    expect_rd(6, 8'h00, "R8 year"); expect_rd(7, 8'h21, "R8 century");
    expect_rd(0, 8'h00, "R2 sec");

    // R2 R5 R6: run, freeze while running, partial load
    wr(4'h8, 8'h01);
    idle(DIV + DIV / 2);
    wr(4'h8, 8'h00);
    idle(3 * DIV);
    expect_rd(0, 8'h01, "R5 frozen sec");
    wr(4'h1, 8'h10);
    expect_rd(1, 8'h10, "R5 written min");
    wr(4'h8, 8'h01);
    wr(4'h8, 8'h02);
    idle(2);
    expect_rd(0, 8'h04, "R6 running sec kept");
    expect_rd(1, 8'h10, "R6 loaded min");
    expect_rd(2, 8'h00, "R6 hour kept");

    // R11 reference output
    wr(4'h8, 8'h06);
    @(negedge clk); chk_pin(refOut, 1'b1, "R11 enabled");
    refEn = 1'b0;
    @(negedge clk); chk_pin(refOut, 1'b0, "R11 follows refEn");
    refEn = 1'b1;
    wr(4'h8, 8'h02);
    @(negedge clk); chk_pin(refOut, 1'b0, "R11 disabled");

    idle(3);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule